// File: doc/BRIEF.md
# Radio Transmit Front-End Sequencer

The sequencer steps the radio front end through a fixed power-up and power-down order around each packet transmission. A transmit request from the MAC starts the ramp-up. The front-end supply enable is driven low first. The transmit/receive switch pair then moves to the transmit side, the baseband transmit enable rises, and the power amplifier enable comes on last. Each gap is a cycle count set by a parameter.

Shutdown has its own order. The end-of-data indication from the MAC removes the baseband enable on the next edge. The sequencer then holds the amplifier on until the baseband's ready status falls, which shows that the final symbol has been modulated. The amplifier is switched off at once. After programmed gaps the switch returns to receive and the supply enable goes high again. A timeout on the ready wait forces the shutdown when the status never falls, and it flags an error. Busy and a one-cycle done pulse tell the MAC when another packet may start.

Top module: `tx_frontend_seq`

## Requirements
- R1: After reset and whenever idle, fe_pwr_n=1, sw_tx=0, sw_rx=1, bb_tx_en=0, pa_en=0, busy=0, done=0. timeout_err=0 after reset.
- R2: A request sampled high while idle drives fe_pwr_n low on that edge. sw_tx rises PWR_TO_SW cycles later. bb_tx_en rises SW_TO_EN cycles after that, and pa_en rises EN_TO_PA cycles after that.
- R3: sw_rx is the inverse of sw_tx on every cycle.
- R4: data_end sampled high while the amplifier is on clears bb_tx_en on that edge. data_end at any other time has no effect on the outputs.
- R5: With bb_tx_en off and pa_en on, pa_en clears on the first edge where bb_ready is sampled low. If bb_ready is already low, this is one cycle after bb_tx_en clears.
- R6: sw_tx falls PA_TO_SW cycles after pa_en falls, and fe_pwr_n rises SW_TO_PWR cycles after that.
- R7: If bb_ready stays high for RDY_TIMEOUT cycles after bb_tx_en clears, pa_en clears and timeout_err sets on the same edge. timeout_err stays set until the next request is accepted.
- R8: A request made while busy does not restart or alter the running sequence. A request that is still high on the first idle cycle starts a new sequence on the next edge.
- R9: busy equals the inverse of fe_pwr_n. done is high for exactly one cycle, on the cycle in which fe_pwr_n has just returned high.
- R10: pa_en is high only while sw_tx is high and fe_pwr_n is low. bb_tx_en is high only while sw_tx is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_req | input | 1 | Transmit request from the MAC |
| data_end | input | 1 | Last data bit has left the MAC |
| bb_ready | input | 1 | Baseband transmit status; low once the final symbol is modulated |
| fe_pwr_n | output | 1 | Front-end power enable, active low |
| sw_tx | output | 1 | Antenna switch, transmit side |
| sw_rx | output | 1 | Antenna switch, receive side (complement) |
| bb_tx_en | output | 1 | Baseband transmit enable |
| pa_en | output | 1 | Power amplifier enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| timeout_err | output | 1 | Ready wait timed out in the last sequence |

## Verification
The assertions check these on every cycle:
- the switch pair stays complementary;
- the amplifier and baseband enables are never on without the switch and supply;
- busy tracks the supply enable;
- done is a single pulse.

They also check causes at the edges where signals fall. The baseband enable falls only after end-of-data. The amplifier falls only on a low ready or a timeout. The supply rises only after a request.

The exact cycle gaps between steps cannot be seen by the assertions. Nor can the ready wait of several cycles, the error flag holding across idle, or a held request chaining into a second sequence. Those are shown only by the bench's scenarios, which compare every output change against an expected vector and gap.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PWR   = 3'd1,
      ST_SW    = 3'd2,
      ST_EN    = 3'd3,
      ST_TX    = 3'd4,
      ST_WAIT  = 3'd5,
      ST_PAOFF = 3'd6,
      ST_SWOFF = 3'd7
   } seq_state_t;

   typedef struct packed {
      logic pwr_n;
      logic sw_tx;
      logic bb_en;
      logic pa_en;
   } fe_ctrl_t;

endpackage

// File: rtl/txseq_timer.sv
module txseq_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   output logic             hit
);
   logic [CNT_W-1:0] cnt;

   assign hit = (cnt == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (!hit)    cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/txseq_fsm.sv
module txseq_fsm
   import txseq_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PWR_TO_SW   = 13,
   parameter int SW_TO_EN    = 375,
   parameter int EN_TO_PA    = 125,
   parameter int PA_TO_SW    = 125,
   parameter int SW_TO_PWR   = 13,
   parameter int RDY_TIMEOUT = 4096
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_req,
   input  logic             data_end,
   input  logic             bb_ready,
   input  logic             hit,
   output seq_state_t       state,
   output logic [CNT_W-1:0] limit,
   output logic             restart,
   output logic             err,
   output logic             done
);
   seq_state_t nxt;

   always_comb begin
      case (state)
         ST_PWR:   limit = CNT_W'(PWR_TO_SW);
         ST_SW:    limit = CNT_W'(SW_TO_EN);
         ST_EN:    limit = CNT_W'(EN_TO_PA);
         ST_WAIT:  limit = CNT_W'(RDY_TIMEOUT);
         ST_PAOFF: limit = CNT_W'(PA_TO_SW);
         ST_SWOFF: limit = CNT_W'(SW_TO_PWR);
         default:  limit = CNT_W'(1);
      endcase
   end

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:  if (tx_req)              nxt = ST_PWR;
         ST_PWR:   if (hit)                 nxt = ST_SW;
         ST_SW:    if (hit)                 nxt = ST_EN;
         ST_EN:    if (hit)                 nxt = ST_TX;
         ST_TX:    if (data_end)            nxt = ST_WAIT;
         ST_WAIT:  if (!bb_ready || hit)    nxt = ST_PAOFF;
         ST_PAOFF: if (hit)                 nxt = ST_SWOFF;
         ST_SWOFF: if (hit)                 nxt = ST_IDLE;
         default:                           nxt = ST_IDLE;
      endcase
   end

   assign restart = (nxt != state);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         err   <= 1'b0;
         done  <= 1'b0;
      end else begin
         state <= nxt;
         done  <= (state == ST_SWOFF) && hit;
         if (state == ST_IDLE && tx_req)
            err <= 1'b0;
         else if (state == ST_WAIT && bb_ready && hit)
            err <= 1'b1;
      end
   end
endmodule

// File: rtl/txseq_drive.sv
module txseq_drive
   import txseq_pkg::*;
(
   input  seq_state_t state,
   output fe_ctrl_t   ctrl,
   output logic       busy
);
   always_comb begin
      ctrl.pwr_n = (state == ST_IDLE);
      ctrl.sw_tx = (state inside {ST_SW, ST_EN, ST_TX, ST_WAIT, ST_PAOFF});
      ctrl.bb_en = (state inside {ST_EN, ST_TX});
      ctrl.pa_en = (state inside {ST_TX, ST_WAIT});
      busy       = (state != ST_IDLE);
   end
endmodule

// File: rtl/tx_frontend_seq.sv
module tx_frontend_seq
   import txseq_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PWR_TO_SW   = 13,
   parameter int SW_TO_EN    = 375,
   parameter int EN_TO_PA    = 125,
   parameter int PA_TO_SW    = 125,
   parameter int SW_TO_PWR   = 13,
   parameter int RDY_TIMEOUT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_req,
   input  logic data_end,
   input  logic bb_ready,
   output logic fe_pwr_n,
   output logic sw_tx,
   output logic sw_rx,
   output logic bb_tx_en,
   output logic pa_en,
   output logic busy,
   output logic done,
   output logic timeout_err
);
   localparam longint CNT_MAX = (longint'(1) << CNT_W) - 1;

   if (CNT_W < 2 || CNT_W > 31) begin : g_bad_width
      $error("CNT_W out of range");
   end
   if (PWR_TO_SW < 1 || SW_TO_EN < 1 || EN_TO_PA < 1 ||
       PA_TO_SW < 1 || SW_TO_PWR < 1 || RDY_TIMEOUT < 1) begin : g_bad_delay
      $error("every delay must be at least one cycle");
   end
   if (PWR_TO_SW > CNT_MAX || SW_TO_EN > CNT_MAX || EN_TO_PA > CNT_MAX ||
       PA_TO_SW > CNT_MAX || SW_TO_PWR > CNT_MAX || RDY_TIMEOUT > CNT_MAX) begin : g_bad_range
      $error("a delay does not fit in CNT_W bits");
   end

   seq_state_t       state;
   logic [CNT_W-1:0] limit;
   logic             restart;
   logic             hit;
   fe_ctrl_t         ctrl;

   txseq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .limit   (limit),
      .hit     (hit)
   );

   txseq_fsm #(
      .CNT_W       (CNT_W),
      .PWR_TO_SW   (PWR_TO_SW),
      .SW_TO_EN    (SW_TO_EN),
      .EN_TO_PA    (EN_TO_PA),
      .PA_TO_SW    (PA_TO_SW),
      .SW_TO_PWR   (SW_TO_PWR),
      .RDY_TIMEOUT (RDY_TIMEOUT)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_req   (tx_req),
      .data_end (data_end),
      .bb_ready (bb_ready),
      .hit      (hit),
      .state    (state),
      .limit    (limit),
      .restart  (restart),
      .err      (timeout_err),
      .done     (done)
   );

   txseq_drive u_drive (
      .state (state),
      .ctrl  (ctrl),
      .busy  (busy)
   );

   assign fe_pwr_n = ctrl.pwr_n;
   assign sw_tx    = ctrl.sw_tx;
   assign sw_rx    = ~ctrl.sw_tx;
   assign bb_tx_en = ctrl.bb_en;
   assign pa_en    = ctrl.pa_en;
endmodule

// File: rtl/txseq_checker.sv
module txseq_checker (
   input logic clk,
   input logic rst_n,
   input logic tx_req,
   input logic data_end,
   input logic bb_ready,
   input logic fe_pwr_n,
   input logic sw_tx,
   input logic sw_rx,
   input logic bb_tx_en,
   input logic pa_en,
   input logic busy,
   input logic done,
   input logic timeout_err
);
   assert_sw_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sw_tx != sw_rx);

   assert_pa_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pa_en |-> (sw_tx && !fe_pwr_n));

   assert_en_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bb_tx_en |-> sw_tx);

   assert_en_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bb_tx_en) |-> $past(data_end));

   assert_pa_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pa_en) |-> (!$past(bb_ready) || $rose(timeout_err)));

   assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fe_pwr_n) |-> $past(tx_req));

   assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fe_pwr_n) |-> !timeout_err);

   assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy != fe_pwr_n);

   assert_done_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $rose(fe_pwr_n));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind tx_frontend_seq txseq_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_req      (tx_req),
   .data_end    (data_end),
   .bb_ready    (bb_ready),
   .fe_pwr_n    (fe_pwr_n),
   .sw_tx       (sw_tx),
   .sw_rx       (sw_rx),
   .bb_tx_en    (bb_tx_en),
   .pa_en       (pa_en),
   .busy        (busy),
   .done        (done),
   .timeout_err (timeout_err)
);

// File: tb/tx_frontend_seq_tb.sv
module tx_frontend_seq_tb;
   localparam int D1  = 3;
   localparam int D2  = 5;
   localparam int D3  = 4;
   localparam int D4  = 2;
   localparam int D5  = 3;
   localparam int TMO = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_req = 1'b0;
   logic data_end = 1'b0;
   logic bb_ready = 1'b0;
   logic fe_pwr_n, sw_tx, sw_rx, bb_tx_en, pa_en, busy, done, timeout_err;

   int n_checks = 0;
   int n_fail = 0;
   int cyc = 0;
   int last_cyc = 0;
   bit mon_en = 1'b0;
   logic [7:0] prev_v;

   logic [7:0] exp_v[$];
   int         exp_g[$];
   string      exp_t[$];

   always #4 clk = ~clk;

   tx_frontend_seq #(
      .CNT_W(8), .PWR_TO_SW(D1), .SW_TO_EN(D2), .EN_TO_PA(D3),
      .PA_TO_SW(D4), .SW_TO_PWR(D5), .RDY_TIMEOUT(TMO)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .data_end(data_end),
      .bb_ready(bb_ready), .fe_pwr_n(fe_pwr_n), .sw_tx(sw_tx), .sw_rx(sw_rx),
      .bb_tx_en(bb_tx_en), .pa_en(pa_en), .busy(busy), .done(done),
      .timeout_err(timeout_err)
   );

   wire [7:0] vec = {fe_pwr_n, sw_tx, sw_rx, bb_tx_en, pa_en, busy, done, timeout_err};

   function automatic logic [7:0] mk(input logic p, input logic s, input logic b,
                                     input logic a, input logic bz, input logic d,
                                     input logic e);
      return {p, s, ~s, b, a, bz, d, e};
   endfunction

   task automatic check(input string tag, input bit ok, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] v, input int g, input string t);
      exp_v.push_back(v);
      exp_g.push_back(g);
      exp_t.push_back(t);
   endtask

   task automatic push_rampup(input int g0);
      push(mk(0,0,0,0,1,0,0), g0, "R2 supply first");
      push(mk(0,1,0,0,1,0,0), D1, "R2 switch to tx");
      push(mk(0,1,1,0,1,0,0), D2, "R2 baseband enable");
      push(mk(0,1,1,1,1,0,0), D3, "R2 amplifier on");
      push(mk(0,1,0,1,1,0,0), -1, "R4 enable off on data_end");
   endtask

   task automatic push_tail(input int pa_gap, input logic e, input bit chained);
      push(mk(0,1,0,0,1,0,e), pa_gap, e ? "R7 timeout shutdown" : "R5 amplifier off");
      push(mk(0,0,0,0,1,0,e), D4, "R6 switch to rx");
      push(mk(1,0,0,0,0,1,e), D5, "R6 R9 supply off with done");
      if (!chained) push(mk(1,0,0,0,0,0,e), 1, "R9 done single cycle");
   endtask

   // monitor: compares every output change against the scoreboard
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (mon_en && vec !== prev_v) begin
         int gap;
         gap = cyc - last_cyc;
         last_cyc = cyc;
         prev_v = vec;
         if (exp_v.size() == 0) begin
            check("R8 unexpected output change", 1'b0, vec, prev_v);
         end else begin
            logic [7:0] ev;
            int eg;
            string et;
            ev = exp_v.pop_front();
            eg = exp_g.pop_front();
            et = exp_t.pop_front();
            check({et, " vector"}, vec === ev, vec, ev);
            if (eg >= 0) check({et, " gap"}, gap == eg, gap, eg);
         end
      end
   end

   task automatic pulse_end();
      data_end = 1'b1;
      @(negedge clk);
      data_end = 1'b0;
   endtask

   task automatic wait_pa();
      while (!pa_en) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic start_req();
      @(negedge clk);
      tx_req = 1'b1;
      @(negedge clk);
      tx_req = 1'b0;
   endtask

   initial begin
      int wd = 0;
      forever begin
         @(posedge clk);
         wd++;
         if (wd > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset state", vec === mk(1,0,0,0,0,0,0), vec, mk(1,0,0,0,0,0,0));
      prev_v = vec;
      last_cyc = cyc;
      mon_en = 1'b1;

      // S1: ready already low when the enable drops (R5 immediate)
      push_rampup(-1);
      push_tail(1, 1'b0, 1'b0);
      bb_ready = 1'b1;
      start_req();
      wait_pa();
      bb_ready = 1'b0;
      @(negedge clk);
      pulse_end();
      wait_idle();

      // S2: data_end during ramp-up ignored (R4), ready falls late (R5)
      push_rampup(-1);
      push_tail(6, 1'b0, 1'b0);
      bb_ready = 1'b1;
      start_req();
      while (!sw_tx) @(negedge clk);
      pulse_end();
      while (!bb_tx_en) @(negedge clk);
      pulse_end();
      wait_pa();
      pulse_end();
      repeat (5) @(negedge clk);
      bb_ready = 1'b0;
      wait_idle();

      // S3: ready never falls, timeout forces shutdown (R7)
      push_rampup(-1);
      push_tail(TMO, 1'b1, 1'b0);
      bb_ready = 1'b1;
      start_req();
      wait_pa();
      pulse_end();
      wait_idle();
      check("R7 error held while idle", timeout_err === 1'b1, timeout_err, 1);

      // S4: held request chains two sequences (R8), error clears on accept (R7)
      push_rampup(-1);
      push_tail(1, 1'b0, 1'b1);
      push_rampup(1);
      push_tail(1, 1'b0, 1'b0);
      bb_ready = 1'b0;
      @(negedge clk);
      tx_req = 1'b1;
      wait_pa();
      pulse_end();
      while (!done) @(negedge clk);
      @(negedge clk);
      tx_req = 1'b0;
      wait_pa();
      pulse_end();
      wait_idle();

      check("R8 scoreboard drained", exp_v.size() == 0, exp_v.size(), 0);
      check("R1 idle after runs", vec === mk(1,0,0,0,0,0,0), vec, mk(1,0,0,0,0,0,0));
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule